// File: doc/BRIEF.md
# Supply-Current Measurement Command Sequencer

This block drives a DDR3-style command bus with the fixed, repeating command loops used while a bench instrument measures one standard supply-current condition of a memory device. A mode code picks the condition. A start pulse latches the mode and the programmable timing counts. The block then loops by itself until a stop request arrives. The loops cover activate/precharge cycling, activate-read-precharge cycling, precharged and active standby, precharged power-down, interleaved burst reads and writes, back-to-back refresh, and activate with read-auto-precharge to successive banks.

Every command leaves the block on a registered bus of command code, bank, row, column and data pattern. On any cycle with nothing to send, a NOP is driven. Commands are spaced by programmable cycle counts for activate-to-precharge, precharge recovery, activate-to-column, activate-to-activate and refresh recovery. A fixed parameter sets the spacing of consecutive column accesses. A stop request closes every bank and then reports completion with a one-cycle flag.

Top module: `idd_loop_sequencer`

## Requirements
- R1: While and after reset, cmd_o is NOP (0), cke_o is 1, busy_o and done_o are 0, and bank_o, row_o, col_o and pat_o are 0. The command codes are NOP=0, ACT=1, PRE=2, PREA=3 (precharge all banks), RD=4, WR=5, RDA=6, REF=7. A spacing of N means that the next command appears on cmd_o N cycles after the previous one.
- R2: A start pulse while idle latches mode_i and the five timing inputs, and sets busy_o. The mode codes are 0 act-pre, 1 act-read-pre, 2 precharged standby, 3 precharged power-down, 4 active standby, 5 burst read, 6 burst write, 7 burst refresh, 8 act-read-auto-precharge. Changes to the timing inputs during a run have no effect. A start pulse while busy is ignored. A start pulse with a mode code above 8 is ignored.
- R3: Mode 0 repeats ACT, then PRE after t_ras_i, then the next ACT after t_rp_i.
- R4: Mode 1 repeats ACT, RD after t_rcd_i, PRE, and the next ACT after t_rp_i. The PRE comes at t_ras_i after the ACT, but never earlier than one cycle after the RD.
- R5: Modes 2 and 3 send one PREA and then only NOPs. In mode 3, cke_o falls t_rp_i cycles after the PREA and stays low until a stop request. While cke_o is low, no command is driven.
- R6: Mode 4 sends ACT to banks 0 through 7 in order, spaced by t_rrd_i, and then only NOPs.
- R7: Modes 5 and 6 send ACT to banks 0 through 7 spaced by t_rrd_i. After the last ACT they wait t_rcd_i and then send RD (mode 5) or WR (mode 6) accesses spaced by COL_GAP (4). Each access goes to the next bank. The column starts at 0 and increments after each access to bank 7.
- R8: A WR carries pat_o 0x00 on even columns and 0x33 on odd columns. In modes 0 and 1, the ACTs alternate between row 0 with pat_o 0xF0 and row 1 with pat_o 0x00, starting at row 0. Fields a command does not use are 0: PRE goes to bank 0.
- R9: Mode 7 sends REF commands spaced by t_rfc_i.
- R10: Mode 8 sends ACT bank b, then RDA bank b after t_rcd_i, then ACT to bank b+1. That next ACT comes at t_rrd_i after the previous ACT, but never earlier than one cycle after the RDA.
- R11: On a stop pulse, no further loop command is sent. Once every pending spacing has elapsed, the block waits one cycle with cke_o high and sends PREA. t_rp_i cycles after the PREA, done_o pulses for one cycle and busy_o falls. The next start begins at bank 0, column 0 and row 0.
- R12: A timing value of 0 behaves as a spacing of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a loop in the selected mode (idle only) |
| stop_i | input | 1 | Request the end of the running loop |
| mode_i | input | 4 | Measurement condition code |
| t_ras_i | input | TW | Activate-to-precharge spacing |
| t_rp_i | input | TW | Precharge recovery spacing |
| t_rcd_i | input | TW | Activate-to-column spacing |
| t_rrd_i | input | TW | Activate-to-activate spacing |
| t_rfc_i | input | TW | Refresh recovery spacing |
| cmd_o | output | 3 | Command code |
| cke_o | output | 1 | Clock enable toward the device |
| bank_o | output | BW | Bank field |
| row_o | output | RW | Row field |
| col_o | output | CW | Column field |
| pat_o | output | DW | Data / row pattern accompanying the command |
| busy_o | output | 1 | A loop or its stop sequence is in progress |
| done_o | output | 1 | One-cycle pulse when the stop sequence ends |

## Verification
Each mode runs with its own timing values, so that each spacing rule shows up as a distinct gap on the command bus. The act-read-pre loop runs twice: once with a long activate-to-precharge count, so that the PRE waits for it, and once with a count shorter than the read delay, so that the PRE follows the RD by one cycle and a zero recovery count acts as one. The burst-write run crosses the bank wrap, which separates a correct column step and the 0x00/0x33 alternation from a stuck column. The burst read that follows separates a restart at bank 0 from a leftover counter. Stops placed after commands with different pending spacings check that the final PREA waits for the longest one. Timing changes, and a start pulse during a run, show whether any input is taken outside idle.

// File: rtl/idd_seq_pkg.sv
package idd_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_PRE  = 3'd2,
    CMD_PREA = 3'd3,
    CMD_RD   = 3'd4,
    CMD_WR   = 3'd5,
    CMD_RDA  = 3'd6,
    CMD_REF  = 3'd7
  } cmd_e;

  typedef enum logic [3:0] {
    M_ACTPRE   = 4'd0,
    M_ACTRDPRE = 4'd1,
    M_PSTBY    = 4'd2,
    M_PPD      = 4'd3,
    M_ASTBY    = 4'd4,
    M_BRD      = 4'd5,
    M_BWR      = 4'd6,
    M_REFB     = 4'd7,
    M_RDAP     = 4'd8
  } mode_e;

  localparam logic [3:0] MODE_LAST = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_HOLD,
    ST_SPRE,
    ST_SWAIT
  } state_e;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load_i) begin
      cnt_n = (val_i == '0) ? '0 : val_i - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o); // R12

endmodule

// File: rtl/seq_addr.sv
module seq_addr #(
  parameter int BW = 3,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          bank_inc_i,
  input  logic          col_inc_i,
  input  logic          par_tog_i,
  output logic [BW-1:0] bank_o,
  output logic [CW-1:0] col_o,
  output logic          par_o,
  output logic          last_bank_o
);

  localparam int BANKS = 1 << BW;

  logic [BW-1:0] bank_q, bank_n;
  logic [CW-1:0] col_q, col_n;
  logic          par_q, par_n;

  always_comb begin
    bank_n = bank_q;
    col_n  = col_q;
    par_n  = par_q;
    if (clr_i) begin
      bank_n = '0;
      col_n  = '0;
      par_n  = 1'b0;
    end else begin
      if (bank_inc_i) bank_n = bank_q + 1'b1;
      if (col_inc_i)  col_n  = col_q + 1'b1;
      if (par_tog_i)  par_n  = ~par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      col_q  <= '0;
      par_q  <= 1'b0;
    end else begin
      bank_q <= bank_n;
      col_q  <= col_n;
      par_q  <= par_n;
    end
  end

  assign bank_o      = bank_q;
  assign col_o       = col_q;
  assign par_o       = par_q;
  assign last_bank_o = (bank_q == BW'(BANKS - 1));

  AST_BANK_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_inc_i && !clr_i && last_bank_o) |=> (bank_o == '0)); // R7

endmodule

// File: rtl/idd_loop_sequencer.sv
module idd_loop_sequencer
  import idd_seq_pkg::*;
#(
  parameter int          TW      = 8,
  parameter int          BW      = 3,
  parameter int          RW      = 15,
  parameter int          CW      = 10,
  parameter int          DW      = 8,
  parameter int          COL_GAP = 4,
  parameter logic [7:0]  PAT_EVEN = 8'h00,
  parameter logic [7:0]  PAT_ODD  = 8'h33,
  parameter logic [7:0]  ROW_PAT0 = 8'hF0,
  parameter logic [7:0]  ROW_PAT1 = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [3:0]    mode_i,
  input  logic [TW-1:0] t_ras_i,
  input  logic [TW-1:0] t_rp_i,
  input  logic [TW-1:0] t_rcd_i,
  input  logic [TW-1:0] t_rrd_i,
  input  logic [TW-1:0] t_rfc_i,
  output logic [2:0]    cmd_o,
  output logic          cke_o,
  output logic [BW-1:0] bank_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic [DW-1:0] pat_o,
  output logic          busy_o,
  output logic          done_o
);

  localparam logic [TW-1:0] COL_GAP_T = TW'(COL_GAP);
  localparam logic [TW-1:0] ONE_T     = TW'(1);

  state_e        st_q, st_n;
  mode_e         mode_q, mode_n;
  logic [1:0]    ph_q, ph_n;
  logic [TW-1:0] ras_q, rp_q, rcd_q, rrd_q, rfc_q;
  logic          t_load;
  logic          stop_pend_q, stop_pend_n, stop_hit;

  logic          g_ld, a_ld, g_zero, a_zero;
  logic [TW-1:0] g_val, a_val;
  logic          a_clr, b_inc, c_inc, p_tog;
  logic [BW-1:0] cur_bank;
  logic [CW-1:0] cur_col;
  logic          cur_par, last_bank;

  cmd_e          cmd_n;
  logic [BW-1:0] bank_n;
  logic [RW-1:0] row_n;
  logic [CW-1:0] col_n;
  logic [DW-1:0] pat_n;
  logic          cke_n, done_n;
  logic [2:0]    cmd_q;
  logic [BW-1:0] bank_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [DW-1:0] pat_q;
  logic          cke_q, done_q;

  seq_timer #(.TW(TW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load_i(g_ld), .val_i(g_val), .zero_o(g_zero)
  );

  seq_timer #(.TW(TW)) u_act (
    .clk(clk), .rst_n(rst_n), .load_i(a_ld), .val_i(a_val), .zero_o(a_zero)
  );

  seq_addr #(.BW(BW), .CW(CW)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr_i(a_clr), .bank_inc_i(b_inc),
    .col_inc_i(c_inc), .par_tog_i(p_tog), .bank_o(cur_bank),
    .col_o(cur_col), .par_o(cur_par), .last_bank_o(last_bank)
  );

  assign stop_hit = stop_i | stop_pend_q;

  always_comb begin
    st_n   = st_q;
    ph_n   = ph_q;
    mode_n = mode_q;
    t_load = 1'b0;
    cmd_n  = CMD_NOP;
    bank_n = '0;
    row_n  = '0;
    col_n  = '0;
    pat_n  = '0;
    g_ld   = 1'b0;
    g_val  = '0;
    a_ld   = 1'b0;
    a_val  = '0;
    a_clr  = 1'b0;
    b_inc  = 1'b0;
    c_inc  = 1'b0;
    p_tog  = 1'b0;
    done_n = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i && (mode_i <= MODE_LAST)) begin
          st_n   = ST_RUN;
          ph_n   = 2'd0;
          mode_n = mode_e'(mode_i);
          t_load = 1'b1;
          a_clr  = 1'b1;
        end
      end
      ST_RUN: begin
        if (stop_hit) begin
          if (g_zero && a_zero) st_n = ST_SPRE;
        end else if (g_zero) begin
          unique case (mode_q)
            M_ACTPRE, M_ACTRDPRE: begin
              if (ph_q == 2'd0) begin
                cmd_n = CMD_ACT;
                row_n = RW'(cur_par);
                pat_n = DW'(cur_par ? ROW_PAT1 : ROW_PAT0);
                g_ld  = 1'b1;
                if (mode_q == M_ACTPRE) begin
                  g_val = ras_q;
                end else begin
                  g_val = rcd_q;
                  a_ld  = 1'b1;
                  a_val = ras_q;
                end
                ph_n = 2'd1;
              end else if (ph_q == 2'd1 && mode_q == M_ACTRDPRE) begin
                cmd_n = CMD_RD;
                g_ld  = 1'b1;
                g_val = ONE_T;
                ph_n  = 2'd2;
              end else if (a_zero) begin
                cmd_n = CMD_PRE;
                g_ld  = 1'b1;
                g_val = rp_q;
                p_tog = 1'b1;
                ph_n  = 2'd0;
              end
            end
            M_PSTBY, M_PPD: begin
              if (ph_q == 2'd0) begin
                cmd_n = CMD_PREA;
                g_ld  = 1'b1;
                g_val = rp_q;
                ph_n  = 2'd1;
              end else begin
                st_n = ST_HOLD;
              end
            end
            M_ASTBY, M_BRD, M_BWR: begin
              if (ph_q == 2'd0) begin
                cmd_n  = CMD_ACT;
                bank_n = cur_bank;
                g_ld   = 1'b1;
                g_val  = rrd_q;
                b_inc  = 1'b1;
                if (last_bank) begin
                  if (mode_q == M_ASTBY) begin
                    st_n = ST_HOLD;
                  end else begin
                    g_val = rcd_q;
                    ph_n  = 2'd1;
                  end
                end
              end else begin
                cmd_n  = (mode_q == M_BWR) ? CMD_WR : CMD_RD;
                bank_n = cur_bank;
                col_n  = cur_col;
                if (mode_q == M_BWR) pat_n = DW'(cur_col[0] ? PAT_ODD : PAT_EVEN);
                g_ld   = 1'b1;
                g_val  = COL_GAP_T;
                b_inc  = 1'b1;
                c_inc  = last_bank;
              end
            end
            M_REFB: begin
              cmd_n = CMD_REF;
              g_ld  = 1'b1;
              g_val = rfc_q;
            end
            default: begin
              if (ph_q == 2'd0) begin
                if (a_zero) begin
                  cmd_n  = CMD_ACT;
                  bank_n = cur_bank;
                  g_ld   = 1'b1;
                  g_val  = rcd_q;
                  a_ld   = 1'b1;
                  a_val  = rrd_q;
                  ph_n   = 2'd1;
                end
              end else begin
                cmd_n  = CMD_RDA;
                bank_n = cur_bank;
                g_ld   = 1'b1;
                g_val  = ONE_T;
                b_inc  = 1'b1;
                ph_n   = 2'd0;
              end
            end
          endcase
        end
      end
      ST_HOLD: begin
        if (stop_hit && g_zero && a_zero) st_n = ST_SPRE;
      end
      ST_SPRE: begin
        cmd_n = CMD_PREA;
        g_ld  = 1'b1;
        g_val = rp_q;
        st_n  = ST_SWAIT;
      end
      default: begin
        if (g_zero) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end
      end
    endcase
    cke_n       = !(st_n == ST_HOLD && mode_q == M_PPD);
    stop_pend_n = (st_n == ST_IDLE) ? 1'b0 : (stop_pend_q | (stop_i && st_q != ST_IDLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      ph_q        <= 2'd0;
      mode_q      <= M_ACTPRE;
      stop_pend_q <= 1'b0;
      cmd_q       <= CMD_NOP;
      bank_q      <= '0;
      row_q       <= '0;
      col_q       <= '0;
      pat_q       <= '0;
      cke_q       <= 1'b1;
      done_q      <= 1'b0;
    end else begin
      st_q        <= st_n;
      ph_q        <= ph_n;
      mode_q      <= mode_n;
      stop_pend_q <= stop_pend_n;
      cmd_q       <= cmd_n;
      bank_q      <= bank_n;
      row_q       <= row_n;
      col_q       <= col_n;
      pat_q       <= pat_n;
      cke_q       <= cke_n;
      done_q      <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= '0;
      rp_q  <= '0;
      rcd_q <= '0;
      rrd_q <= '0;
      rfc_q <= '0;
    end else if (t_load) begin
      ras_q <= t_ras_i;
      rp_q  <= t_rp_i;
      rcd_q <= t_rcd_i;
      rrd_q <= t_rrd_i;
      rfc_q <= t_rfc_i;
    end
  end

  assign cmd_o  = cmd_q;
  assign bank_o = bank_q;
  assign row_o  = row_q;
  assign col_o  = col_q;
  assign pat_o  = pat_q;
  assign cke_o  = cke_q;
  assign done_o = done_q;
  assign busy_o = (st_q != ST_IDLE);

  AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> (cmd_o == CMD_NOP)); // R5

  AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_NOP) |-> $past(busy_o)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R11

  AST_WR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_WR) |-> (pat_o == DW'(PAT_EVEN) || pat_o == DW'(PAT_ODD))); // R8

endmodule

// File: tb/sim_idd_loop_sequencer.sv
module sim_idd_loop_sequencer;

  logic       clk, rst_n, start_i, stop_i;
  logic [3:0] mode_i;
  logic [7:0] t_ras_i, t_rp_i, t_rcd_i, t_rrd_i, t_rfc_i;
  logic [2:0] cmd_o, bank_o;
  logic       cke_o, busy_o, done_o;
  logic [14:0] row_o;
  logic [9:0]  col_o;
  logic [7:0]  pat_o;

  idd_loop_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .mode_i(mode_i),
    .t_ras_i(t_ras_i), .t_rp_i(t_rp_i), .t_rcd_i(t_rcd_i), .t_rrd_i(t_rrd_i),
    .t_rfc_i(t_rfc_i), .cmd_o(cmd_o), .cke_o(cke_o), .bank_o(bank_o), .row_o(row_o),
    .col_o(col_o), .pat_o(pat_o), .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int cmd; int bank; int row; int col; int pat; int gap; string tag;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    last_cyc = 0;
  string cur_tag = "R1";

  task automatic push(input int c, input int b, input int r, input int co,
                      input int p, input int g, input string t);
    exp_t e;
    e.cmd = c; e.bank = b; e.row = r; e.col = co; e.pat = p; e.gap = g; e.tag = t;
    q.push_back(e);
  endtask

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && cmd_o != 3'd0) begin
      if (q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL %s unexpected command: actual cmd %0d bank %0d expected none",
                 cur_tag, cmd_o, bank_o);
      end else begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (int'(cmd_o) != e.cmd || int'(bank_o) != e.bank || int'(row_o) != e.row ||
            int'(col_o) != e.col || int'(pat_o) != e.pat ||
            (e.gap >= 0 && (cyc - last_cyc) != e.gap)) begin
          fails++;
          $display("FAIL %s cmd/bank/row/col/pat/gap: actual %0d/%0d/%0d/%0d/%0h/%0d expected %0d/%0d/%0d/%0d/%0h/%0d",
                   e.tag, cmd_o, bank_o, row_o, col_o, pat_o, cyc - last_cyc,
                   e.cmd, e.bank, e.row, e.col, e.pat, e.gap);
        end
      end
      last_cyc = cyc;
    end
  end

  task automatic wait_drain();
    while (q.size() != 0) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic go(input int m, input int ras, input int rp, input int rcd,
                    input int rrd, input int rfc);
    mode_i = 4'(m); t_ras_i = 8'(ras); t_rp_i = 8'(rp); t_rcd_i = 8'(rcd);
    t_rrd_i = 8'(rrd); t_rfc_i = 8'(rfc);
    start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_i = 1'b1;
    @(negedge clk); #1;
    stop_i = 1'b0;
  endtask

  // stop after the queue drains; final PREA expected with gap g, done after rp cycles
  task automatic finish_run(input int g, input int rp, input string t);
    wait_drain();
    push(3, 0, 0, 0, 0, g, t);
    pulse_stop();
    wait_drain();
    chk(t, "done before recovery", int'(done_o), 0);
    repeat (rp) @(negedge clk);
    chk(t, "done pulse", int'(done_o), 1);
    chk(t, "busy after done", int'(busy_o), 0);
    @(negedge clk);
    chk(t, "done single cycle", int'(done_o), 0);
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 100000; wd++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; mode_i = 4'd0;
    t_ras_i = 8'd1; t_rp_i = 8'd1; t_rcd_i = 8'd1; t_rrd_i = 8'd1; t_rfc_i = 8'd1;
    repeat (3) @(negedge clk);
    chk("R1", "cmd in reset", int'(cmd_o), 0);
    chk("R1", "cke in reset", int'(cke_o), 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "busy after reset", int'(busy_o), 0);
    chk("R1", "done after reset", int'(done_o), 0);
    chk("R1", "pat after reset", int'(pat_o), 0);

    // R3 act-pre loop, R2 timing changes ignored during a run
    cur_tag = "R3";
    push(1, 0, 0, 0, 8'hF0, -1, "R3");
    push(2, 0, 0, 0, 0, 5, "R3");
    push(1, 0, 1, 0, 8'h00, 3, "R8");
    push(2, 0, 0, 0, 0, 5, "R2");
    push(1, 0, 0, 0, 8'hF0, 3, "R3");
    go(0, 5, 3, 1, 1, 1);
    chk("R2", "busy after start", int'(busy_o), 1);
    t_ras_i = 8'd9; t_rp_i = 8'd7;
    finish_run(6, 3, "R11");

    // R4 act-read-pre with tRAS governing the PRE
    cur_tag = "R4";
    push(1, 0, 0, 0, 8'hF0, -1, "R4");
    push(4, 0, 0, 0, 0, 3, "R4");
    push(2, 0, 0, 0, 0, 4, "R4");
    push(1, 0, 1, 0, 8'h00, 2, "R4");
    push(4, 0, 0, 0, 0, 3, "R4");
    push(2, 0, 0, 0, 0, 4, "R4");
    go(1, 7, 2, 3, 1, 1);
    finish_run(3, 2, "R11");

    // R4 with tRAS shorter than tRCD, R12 zero recovery acts as one
    cur_tag = "R12";
    push(1, 0, 0, 0, 8'hF0, -1, "R4");
    push(4, 0, 0, 0, 0, 4, "R4");
    push(2, 0, 0, 0, 0, 1, "R4");
    push(1, 0, 1, 0, 8'h00, 1, "R12");
    push(4, 0, 0, 0, 0, 4, "R12");
    go(1, 2, 0, 4, 1, 1);
    finish_run(2, 1, "R12");

    // R5 precharged power-down
    cur_tag = "R5";
    push(3, 0, 0, 0, 0, -1, "R5");
    go(3, 1, 4, 1, 1, 1);
    wait_drain();
    repeat (3) @(negedge clk);
    chk("R5", "cke before recovery end", int'(cke_o), 1);
    @(negedge clk);
    chk("R5", "cke low after recovery", int'(cke_o), 0);
    repeat (10) @(negedge clk);
    chk("R5", "cke stays low", int'(cke_o), 0);
    #1;
    push(3, 0, 0, 0, 0, -1, "R11");
    pulse_stop();
    chk("R11", "cke raised before PREA", int'(cke_o), 1);
    wait_drain();
    repeat (4) @(negedge clk);
    chk("R11", "done after power-down", int'(done_o), 1);
    repeat (3) @(negedge clk); #1;

    // R5 precharged standby
    push(3, 0, 0, 0, 0, -1, "R5");
    go(2, 1, 2, 1, 1, 1);
    repeat (20) @(negedge clk);
    chk("R5", "cke in standby", int'(cke_o), 1);
    #1;
    push(3, 0, 0, 0, 0, -1, "R11");
    pulse_stop();
    wait_drain();
    repeat (2) @(negedge clk);
    chk("R11", "done after standby", int'(done_o), 1);
    repeat (3) @(negedge clk); #1;

    // R6 active standby
    cur_tag = "R6";
    for (int b = 0; b < 8; b++) push(1, b, 0, 0, 0, (b == 0) ? -1 : 2, "R6");
    go(4, 1, 2, 1, 2, 1);
    wait_drain();
    repeat (15) @(negedge clk);
    chk("R6", "busy while open", int'(busy_o), 1);
    #1;
    push(3, 0, 0, 0, 0, -1, "R11");
    pulse_stop();
    wait_drain();
    repeat (2) @(negedge clk);
    chk("R11", "done after active standby", int'(done_o), 1);
    repeat (3) @(negedge clk); #1;

    // R7 burst write across the bank wrap, R8 patterns
    cur_tag = "R7";
    for (int b = 0; b < 8; b++) push(1, b, 0, 0, 0, (b == 0) ? -1 : 1, "R7");
    push(5, 0, 0, 0, 8'h00, 3, "R7");
    for (int b = 1; b < 8; b++) push(5, b, 0, 0, 8'h00, 4, "R8");
    push(5, 0, 0, 1, 8'h33, 4, "R8");
    push(5, 1, 0, 1, 8'h33, 4, "R7");
    go(6, 1, 2, 3, 1, 1);
    finish_run(5, 2, "R11");

    // R7 burst read; R11 restart at bank 0 and column 0
    for (int b = 0; b < 8; b++) push(1, b, 0, 0, 0, (b == 0) ? -1 : 2, "R11");
    push(4, 0, 0, 0, 0, 2, "R11");
    push(4, 1, 0, 0, 0, 4, "R7");
    push(4, 2, 0, 0, 0, 4, "R7");
    go(5, 1, 3, 2, 2, 1);
    finish_run(5, 3, "R11");

    // R9 burst refresh; R2 start while busy ignored
    cur_tag = "R9";
    for (int k = 0; k < 4; k++) push(7, 0, 0, 0, 0, (k == 0) ? -1 : 6, "R9");
    go(7, 1, 2, 1, 1, 6);
    repeat (2) @(negedge clk); #1;
    go(0, 1, 1, 1, 1, 1);
    finish_run(7, 2, "R2");

    // R10 act / read-auto-precharge interleave
    cur_tag = "R10";
    push(1, 0, 0, 0, 0, -1, "R10");
    push(6, 0, 0, 0, 0, 2, "R10");
    push(1, 1, 0, 0, 0, 3, "R10");
    push(6, 1, 0, 0, 0, 2, "R10");
    push(1, 2, 0, 0, 0, 3, "R10");
    go(8, 1, 2, 2, 5, 1);
    finish_run(6, 2, "R11");

    // R2 invalid mode ignored
    cur_tag = "R2";
    go(12, 1, 1, 1, 1, 1);
    repeat (10) @(negedge clk);
    chk("R2", "busy after invalid mode", int'(busy_o), 0);
    chk("R2", "queue empty at end", q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule